// File: doc/BRIEF.md
# Interrupt Distributor With Routing

This block collects interrupt requests from peripherals and from software and hands each CPU of a small multiprocessor cluster the single most urgent request that may go to it. Each interrupt has an enable bit, a pending state, a 4-bit priority and, for shared lines, a CPU target mask. Shared lines can be set up as rising-edge or level-high. Software writes a dedicated register to raise software interrupts on a chosen set of CPUs.

The ID space has three parts. IDs 0 to 15 are software interrupts, and each CPU has its own copy of their pending state. IDs 16 to 31 are private lines, one set of 16 for each CPU. IDs 32 and up are shared lines, which are routed by their target byte. Registers are reached over a single-cycle 32-bit port. Writes take effect on the clock edge where `req_i` and `we_i` are high. Read data appears on `rdata_o` after the edge that accepts the read. `cpu_i` identifies which CPU is making the access, and the registers that are banked per CPU use it.

Top module: `irq_distributor`

## Requirements
- R1: After reset no CPU output is asserted, and the control register at 0x000 reads 0.
- R2: The type register at 0x004 holds NUM_IRQ/32-1 in bits 4:0 and NUM_CPU-1 in bits 7:5.
- R3: The enable state is held in words of 32 IDs each, with bit b of word w standing for ID 32w+b. A 1 written to the set bank (0x100+4w) enables an ID. A 1 written to the clear bank (0x180+4w) disables it. Bits written as 0 change nothing, and either bank reads back the current enable bits.
- R4: Priority byte for ID n sits at 0x400+n, written per byte lane. Only bits 7:4 are stored, and bits 3:0 read as 0.
- R5: Each CPU output shows the eligible interrupt with the numerically lowest priority. When two have equal priority, the lower ID wins. `irq_prio_o` gives the winner's 4-bit priority.
- R6: A shared ID n reaches CPU c only if bit c of its target byte at 0x800+n is set.
- R7: A shared ID whose upper config bit is 1 is edge-triggered. The config word at 0xC00+4*(n/16) holds this bit at position 2*(n%16)+1. A 0-to-1 input transition latches the ID pending, and it stays pending after the input falls until a 1 is written to its bit in the clear-pending bank at 0x280.
- R8: A shared ID whose upper config bit is 0 is level-triggered. It is pending exactly while its input is high, and a clear-pending write has no effect on it.
- R9: A write to 0xF00 sets software interrupt ID wdata[3:0] pending on every CPU c whose bit is set in wdata[16+c]. Writing a 1 to bit n of clear-pending word 0 clears ID n, for n below 16, on the accessing CPU only.
- R10: For IDs 0 to 31 the target byte reads back as 1<<cpu_i and writes to it are ignored. Config pairs read 2'b10 for IDs 0 to 15 and 2'b00 for IDs 16 to 31, and writes to them are ignored. IDs 0 to 15 always behave as edge and IDs 16 to 31 always behave as level.
- R11: While control bit 0 is 0, every CPU output is deasserted. Pending state is kept and can be read from the clear-pending bank as the accessing CPU's pending view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| cpu_i | input | 3 | Index of the accessing CPU |
| rdata_o | output | 32 | Read data, valid after the accepting edge |
| spi_i | input | NUM_IRQ-32 | Shared interrupt inputs, bit j is ID 32+j |
| ppi_i | input | NUM_CPU*16 | Private inputs, bit 16c+k is ID 16+k of CPU c |
| irq_o | output | NUM_CPU | Interrupt request to each CPU |
| irq_id_o | output | NUM_CPU*clog2(NUM_IRQ) | ID of the winning interrupt for each CPU |
| irq_prio_o | output | NUM_CPU*4 | Priority of the winning interrupt for each CPU |

## Verification
The assertions assume that the interrupt inputs are synchronous to `clk_i`. They also assume that `cpu_i` is a valid CPU index whenever `req_i` is high, and that no write to the clear-pending bank falls on the same cycle as an edge it is meant to clear. The stimulus changes inputs only on falling clock edges, issues one access at a time with a legal CPU index, and raises and lowers each edge input well away from any clear-pending write. With that ordering, every pending change can be traced to exactly one cause.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int SGI_N  = 16;
  localparam int PPI_N  = 16;
  localparam int PRIV_N = 32;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_TYPE = 12'h004;
  localparam logic [11:0] A_SGI  = 12'hF00;

  // addr[11:7] block selects
  localparam logic [4:0] BLK_SETEN = 5'h02;
  localparam logic [4:0] BLK_CLREN = 5'h03;
  localparam logic [4:0] BLK_CLRPD = 5'h05;

  // addr[11:10] / addr[11:8] region selects
  localparam logic [1:0] RGN_PRIO = 2'b01;
  localparam logic [1:0] RGN_TGT  = 2'b10;
  localparam logic [3:0] RGN_CFG  = 4'hC;
endpackage

// File: rtl/irq_dist_src.sv
module irq_dist_src #(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SPI-1:0]   spi_i,
  input  logic [NUM_CPU*16-1:0] ppi_i,
  input  logic [NUM_SPI-1:0]   spi_edge_i,
  input  logic [NUM_SPI-1:0]   clr_spi_i,
  input  logic [15:0]          clr_sgi_i,
  input  logic [2:0]           clr_cpu_i,
  input  logic                 sgi_we_i,
  input  logic [7:0]           sgi_tgt_i,
  input  logic [3:0]           sgi_id_i,
  output logic [NUM_CPU*16-1:0] sgi_pend_o,
  output logic [NUM_CPU*16-1:0] ppi_pend_o,
  output logic [NUM_SPI-1:0]   spi_pend_o
);
  logic [NUM_SPI-1:0]    spi_q, edge_q;
  logic [NUM_CPU*16-1:0] ppi_q, sgi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spi_q  <= '0;
      edge_q <= '0;
      ppi_q  <= '0;
    end else begin
      spi_q  <= spi_i;
      ppi_q  <= ppi_i;
      // a new rising edge wins over a clear in the same cycle
      edge_q <= ((edge_q & ~clr_spi_i) | (spi_i & ~spi_q)) & spi_edge_i;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_sgi
    logic [15:0] set_v, clr_v;
    assign set_v = (sgi_we_i && sgi_tgt_i[c]) ? (16'b1 << sgi_id_i) : 16'b0;
    assign clr_v = (clr_cpu_i == 3'(c)) ? clr_sgi_i : 16'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sgi_q[c*16 +: 16] <= '0;
      else         sgi_q[c*16 +: 16] <= (sgi_q[c*16 +: 16] & ~clr_v) | set_v;
    end

    // R9
    sgi_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sgi_we_i && sgi_tgt_i[c]) |=> (|(sgi_q[c*16 +: 16] & (16'b1 << $past(sgi_id_i)))));
  end

  assign sgi_pend_o = sgi_q;
  assign ppi_pend_o = ppi_q;
  assign spi_pend_o = (spi_edge_i & edge_q) | (~spi_edge_i & spi_q);

  // R7
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(edge_q) & ~$past(clr_spi_i) & $past(spi_edge_i) & ~edge_q) == '0));
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb #(
  parameter int NUM_IRQ = 64,
  localparam int IDW    = $clog2(NUM_IRQ)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   elig_i,
  input  logic [NUM_IRQ*4-1:0] prio_i,
  output logic                 valid_o,
  output logic [IDW-1:0]       id_o,
  output logic [3:0]           prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = 4'hF;
    // ascending scan, strict compare keeps the lower ID on ties
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i*4 +: 4] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
        prio_o  = prio_i[i*4 +: 4];
      end
    end
  end

  // R5
  win_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[id_o]);
  // R5
  none_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i == '0) |-> !valid_o);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPU = 2,   // 1..8
  parameter int NUM_IRQ = 64   // multiple of 32, at least 64
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 req_i,
  input  logic                                 we_i,
  input  logic [11:0]                          addr_i,
  input  logic [31:0]                          wdata_i,
  input  logic [3:0]                           be_i,
  input  logic [2:0]                           cpu_i,
  output logic [31:0]                          rdata_o,
  input  logic [NUM_IRQ-33:0]                  spi_i,
  input  logic [NUM_CPU*16-1:0]                ppi_i,
  output logic [NUM_CPU-1:0]                   irq_o,
  output logic [NUM_CPU*$clog2(NUM_IRQ)-1:0]   irq_id_o,
  output logic [NUM_CPU*4-1:0]                 irq_prio_o
);
  localparam int NUM_SPI = NUM_IRQ - PRIV_N;
  localparam int IDW     = $clog2(NUM_IRQ);
  localparam int NWORD   = NUM_IRQ / 32;

  logic                      ctrl_en_q;
  logic [NUM_IRQ-1:0]        en_q;
  logic [NUM_IRQ-1:0][3:0]   prio_q;
  logic [NUM_SPI-1:0][7:0]   tgt_q;
  logic [NUM_SPI-1:0]        edge_cfg_q;
  logic [31:0]               rdata_q;

  logic       wr, rd;
  logic [4:0] blk, word;
  logic       hit_seten, hit_clren, hit_clrpd, hit_prio, hit_tgt, hit_cfg, sgi_we;

  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign blk       = addr_i[11:7];
  assign word      = addr_i[6:2];
  assign hit_seten = wr && blk == BLK_SETEN;
  assign hit_clren = wr && blk == BLK_CLREN;
  assign hit_clrpd = wr && blk == BLK_CLRPD;
  assign hit_prio  = wr && addr_i[11:10] == RGN_PRIO;
  assign hit_tgt   = wr && addr_i[11:10] == RGN_TGT;
  assign hit_cfg   = wr && addr_i[11:8] == RGN_CFG;
  assign sgi_we    = wr && addr_i == A_SGI;

  // ---------------- register writes ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      en_q       <= '0;
      prio_q     <= '0;
      tgt_q      <= '0;
      edge_cfg_q <= '0;
    end else begin
      if (wr && addr_i == A_CTRL && be_i[0]) ctrl_en_q <= wdata_i[0];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (hit_seten && word == 5'(i / 32) && wdata_i[i % 32]) en_q[i] <= 1'b1;
        if (hit_clren && word == 5'(i / 32) && wdata_i[i % 32]) en_q[i] <= 1'b0;
        if (hit_prio && addr_i[9:2] == 8'(i / 4) && be_i[i % 4])
          prio_q[i] <= wdata_i[(i % 4) * 8 + 4 +: 4];
      end
      for (int j = 0; j < NUM_SPI; j++) begin
        if (hit_tgt && addr_i[9:2] == 8'((j + 32) / 4) && be_i[j % 4])
          tgt_q[j] <= wdata_i[(j % 4) * 8 +: 8];
        if (hit_cfg && addr_i[7:2] == 6'((j + 32) / 16) && be_i[(j % 16) / 4])
          edge_cfg_q[j] <= wdata_i[(j % 16) * 2 + 1];
      end
    end
  end

  // ---------------- pending sources ----------------
  logic [NUM_SPI-1:0]    clr_spi, spi_pend;
  logic [15:0]           clr_sgi;
  logic [NUM_CPU*16-1:0] sgi_pend, ppi_pend;

  always_comb begin
    for (int j = 0; j < NUM_SPI; j++)
      clr_spi[j] = hit_clrpd && word == 5'((j + 32) / 32) && wdata_i[(j + 32) % 32];
  end
  assign clr_sgi = (hit_clrpd && word == 5'd0) ? wdata_i[15:0] : 16'b0;

  irq_dist_src #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .spi_i      (spi_i),
    .ppi_i      (ppi_i),
    .spi_edge_i (edge_cfg_q),
    .clr_spi_i  (clr_spi),
    .clr_sgi_i  (clr_sgi),
    .clr_cpu_i  (cpu_i),
    .sgi_we_i   (sgi_we),
    .sgi_tgt_i  (wdata_i[23:16]),
    .sgi_id_i   (wdata_i[3:0]),
    .sgi_pend_o (sgi_pend),
    .ppi_pend_o (ppi_pend),
    .spi_pend_o (spi_pend)
  );

  // ---------------- per-CPU selection ----------------
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] pend_all;
  logic [NUM_IRQ*4-1:0]            prio_flat;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) prio_flat[i*4 +: 4] = prio_q[i];
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SPI-1:0] spi_route;
    logic [NUM_IRQ-1:0] elig;
    logic [IDW-1:0]     win_id;

    always_comb begin
      for (int j = 0; j < NUM_SPI; j++) spi_route[j] = tgt_q[j][c];
    end
    assign pend_all[c] = {spi_pend, ppi_pend[c*16 +: 16], sgi_pend[c*16 +: 16]};
    assign elig = {NUM_IRQ{ctrl_en_q}} & en_q & pend_all[c] & {spi_route, 32'hFFFF_FFFF};

    irq_dist_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .elig_i  (elig),
      .prio_i  (prio_flat),
      .valid_o (irq_o[c]),
      .id_o    (win_id),
      .prio_o  (irq_prio_o[c*4 +: 4])
    );
    assign irq_id_o[c*IDW +: IDW] = win_id;

    // R6
    route_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && win_id >= IDW'(32)) |-> tgt_q[win_id - IDW'(32)][c]);
  end

  // ---------------- register reads ----------------
  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (addr_i == A_CTRL) begin
      rd_d[0] = ctrl_en_q;
    end else if (addr_i == A_TYPE) begin
      rd_d[4:0] = 5'(NWORD - 1);
      rd_d[7:5] = 3'(NUM_CPU - 1);
    end else if (blk == BLK_SETEN || blk == BLK_CLREN) begin
      for (int b = 0; b < 32; b++)
        if (int'(word) * 32 + b < NUM_IRQ) rd_d[b] = en_q[int'(word) * 32 + b];
    end else if (blk == BLK_CLRPD) begin
      for (int b = 0; b < 32; b++)
        if (int'(word) * 32 + b < NUM_IRQ && int'(cpu_i) < NUM_CPU)
          rd_d[b] = pend_all[cpu_i][int'(word) * 32 + b];
    end else if (addr_i[11:10] == RGN_PRIO) begin
      for (int l = 0; l < 4; l++)
        if (int'(addr_i[9:2]) * 4 + l < NUM_IRQ)
          rd_d[l*8 + 4 +: 4] = prio_q[int'(addr_i[9:2]) * 4 + l];
    end else if (addr_i[11:10] == RGN_TGT) begin
      for (int l = 0; l < 4; l++) begin
        if (int'(addr_i[9:2]) * 4 + l < PRIV_N) rd_d[l*8 +: 8] = 8'b1 << cpu_i;
        else if (int'(addr_i[9:2]) * 4 + l < NUM_IRQ)
          rd_d[l*8 +: 8] = tgt_q[int'(addr_i[9:2]) * 4 + l - PRIV_N];
      end
    end else if (addr_i[11:8] == RGN_CFG) begin
      for (int k = 0; k < 16; k++) begin
        if (int'(addr_i[7:2]) * 16 + k < SGI_N) rd_d[2*k + 1] = 1'b1;
        else if (int'(addr_i[7:2]) * 16 + k >= PRIV_N && int'(addr_i[7:2]) * 16 + k < NUM_IRQ)
          rd_d[2*k + 1] = edge_cfg_q[int'(addr_i[7:2]) * 16 + k - PRIV_N];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_d;
  end
  assign rdata_o = rdata_q;

  // R11
  ctrl_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_q |-> (irq_o == '0));
endmodule

// File: tb/irq_distributor_tb.sv
`timescale 1ns/1ps
module irq_distributor_tb;
  localparam int NUM_CPU = 2;
  localparam int NUM_IRQ = 64;
  localparam int IDW     = $clog2(NUM_IRQ);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  req = 1'b0, we = 1'b0;
  logic [11:0]           addr = '0;
  logic [31:0]           wdata = '0;
  logic [3:0]            be = '0;
  logic [2:0]            cpu = '0;
  logic [31:0]           rdata;
  logic [NUM_IRQ-33:0]   spi = '0;
  logic [NUM_CPU*16-1:0] ppi = '0;
  logic [NUM_CPU-1:0]    irq;
  logic [NUM_CPU*IDW-1:0] irq_id;
  logic [NUM_CPU*4-1:0]  irq_prio;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_distributor #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .cpu_i(cpu), .rdata_o(rdata),
    .spi_i(spi), .ppi_i(ppi), .irq_o(irq), .irq_id_o(irq_id), .irq_prio_o(irq_prio)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] b = 4'hF, input logic [2:0] c = 3'd0);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b; cpu = c;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] c, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; cpu = c;
    @(negedge clk);
    d = rdata;
    req = 0;
  endtask

  task automatic exp_irq(input int c, input bit v, input int id, input string tag);
    int aid;
    aid = int'(irq_id[c*IDW +: IDW]);
    if (v) chk(irq[c] && aid == id, tag, irq[c] ? aid : -1, id);
    else   chk(!irq[c], tag, irq[c] ? aid : -1, -1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq == '0, "R1 irq after reset", int'(irq), 0);
    rd(12'h000, 0, d);
    chk(d == 0, "R1 ctrl reset", d, 0);
  endtask

  task automatic t_type();
    logic [31:0] d;
    rd(12'h004, 0, d);
    chk(d == 32'h21, "R2 type reg", d, 32'h21);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(12'h104, 32'h5);
    rd(12'h104, 0, d);
    chk(d == 32'h5, "R3 set-enable", d, 32'h5);
    wr(12'h184, 32'h0);
    rd(12'h104, 0, d);
    chk(d == 32'h5, "R3 zero write no effect", d, 32'h5);
    wr(12'h184, 32'h1);
    rd(12'h184, 0, d);
    chk(d == 32'h4, "R3 clear-enable", d, 32'h4);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h420, 32'h3C5A_FF12, 4'b0101);
    rd(12'h420, 0, d);
    chk(d == 32'h0050_0010, "R4 prio lanes/low bits", d, 32'h0050_0010);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    wr(12'h000, 32'h1);
    wr(12'h820, 32'h0101_0101);
    wr(12'h104, 32'h7);
    wr(12'h420, 32'h0030_3050);
    @(negedge clk); spi[2:0] = 3'b111;
    @(negedge clk);
    exp_irq(0, 1, 33, "R5 tie lower id");
    chk(irq_prio[3:0] == 4'h3, "R5 prio out", irq_prio[3:0], 3);
    exp_irq(1, 0, 0, "R6 not routed");
    spi[1] = 1'b0;
    @(negedge clk);
    exp_irq(0, 1, 34, "R5 next winner");
    wr(12'h820, 32'h0002_0101);
    exp_irq(0, 1, 32, "R6 cpu0 after retarget");
    exp_irq(1, 1, 34, "R6 cpu1 after retarget");
    wr(12'h000, 32'h0);
    chk(irq == '0, "R11 gated", int'(irq), 0);
    rd(12'h284, 0, d);
    chk(d == 32'h5, "R11 pending kept", d, 32'h5);
    wr(12'h000, 32'h1);
    exp_irq(0, 1, 32, "R11 reenabled");
    @(negedge clk); spi = '0;
    wr(12'h184, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(12'hC08, 32'h1 << 17);
    wr(12'h828, 32'h0000_0001, 4'b0001);
    wr(12'h104, 32'h1 << 8);
    @(negedge clk); spi[8] = 1'b1;
    @(negedge clk); spi[8] = 1'b0;
    @(negedge clk);
    exp_irq(0, 1, 40, "R7 edge latched");
    rd(12'h284, 0, d);
    chk(d[8], "R7 pending bit", d, 32'h100);
    wr(12'h284, 32'h1 << 8);
    exp_irq(0, 0, 0, "R7 cleared");
  endtask

  task automatic t_level();
    wr(12'h828, 32'h0000_0101, 4'b0011);
    wr(12'h104, 32'h1 << 9);
    @(negedge clk); spi[9] = 1'b1;
    @(negedge clk);
    exp_irq(0, 1, 41, "R8 level pending");
    wr(12'h284, 32'h1 << 9);
    exp_irq(0, 1, 41, "R8 clear ignored");
    spi[9] = 1'b0;
    @(negedge clk);
    exp_irq(0, 0, 0, "R8 follows input");
  endtask

  task automatic t_sgi();
    wr(12'h100, 32'h28);
    wr(12'hF00, 32'h0002_0005);
    exp_irq(1, 1, 5, "R9 sgi cpu1");
    exp_irq(0, 0, 0, "R9 sgi not cpu0");
    wr(12'hF00, 32'h0003_0003);
    exp_irq(0, 1, 3, "R9 sgi both cpu0");
    exp_irq(1, 1, 3, "R9 sgi both cpu1");
    wr(12'h280, 32'h8, 4'hF, 3'd1);
    exp_irq(1, 1, 5, "R9 clear own cpu");
    exp_irq(0, 1, 3, "R9 other cpu kept");
  endtask

  task automatic t_banked();
    logic [31:0] d;
    rd(12'h804, 1, d);
    chk(d == 32'h0202_0202, "R10 own target cpu1", d, 32'h0202_0202);
    wr(12'h804, 32'h0);
    rd(12'h804, 0, d);
    chk(d == 32'h0101_0101, "R10 target write ignored", d, 32'h0101_0101);
    rd(12'hC00, 0, d);
    chk(d == 32'hAAAA_AAAA, "R10 sgi cfg edge", d, 32'hAAAA_AAAA);
    wr(12'hC04, 32'hFFFF_FFFF);
    rd(12'hC04, 0, d);
    chk(d == 32'h0, "R10 ppi cfg level", d, 0);
    wr(12'h280, 32'h8);
    exp_irq(0, 0, 0, "R10 cpu0 idle");
    wr(12'h100, 32'h1 << 20);
    @(negedge clk); ppi[4] = 1'b1;
    @(negedge clk);
    exp_irq(0, 1, 20, "R10 ppi pending");
    ppi[4] = 1'b0;
    @(negedge clk);
    exp_irq(0, 0, 0, "R10 ppi stays level");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type();
    t_enable();
    t_prio();
    t_arb();
    t_edge();
    t_level();
    t_sgi();
    t_banked();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule